// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block is a 16-bit timer that stays parked until a trigger arrives and then produces exactly one pulse. The pulse begins a programmable number of count ticks after the trigger and lasts for a programmable number of ticks. A trigger comes from one of two places. It can be a selected edge on an external input, which is resynchronised to the system clock. It can also be a one-cycle software strobe.

Counting advances only on system-clock cycles where the count-clock enable is high, so a prescaler outside the block sets the time base. Two compare inputs set the timing. The end compare sets the last count of the pulse, and the delay compare sets the count at which the pulse turns on. Both values are captured when the trigger is accepted. Two single-cycle interrupt outputs mark the ticks where the count equals each captured compare. The output polarity is programmable: a control input gives the inactive level, and the active level is its inverse.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, and while `enable` is low, `count` reads FFFFh, `pulse_out` equals `out_idle_lvl` and both interrupts are low; raising `enable` alone leaves `count` at FFFFh.
- R2: While armed, a high `sw_trig` sampled at a clock edge is a trigger; at that edge `count` becomes 0000h, whatever the value of `cnt_en`.
- R3: With trigger edge P and the c-th tick edge after P called t(c) (t(0)=P), `pulse_out` turns active at edge t(delay)+1; with `cnt_en` held high that is P+delay+1.
- R4: `pulse_out` stays active through edge t(end+1), which is (end − delay + 1) ticks of active level.
- R5: On the tick where `count` equals the captured end value, `count` returns to FFFFh and the timer is armed again for a new trigger.
- R6: Triggers of either kind that arrive between an accepted trigger and the return to FFFFh are ignored.
- R7: `irq_delay` is high for one cycle after the tick where `count` equals the captured delay value, and `irq_end` is high for one cycle after the tick where `count` equals the captured end value.
- R8: `end_val` and `delay_val` are captured at the accepted trigger, so later changes do not affect the pulse in progress.
- R9: `edge_sel` encodes 00 none, 01 rising, 10 falling, 11 both. `ext_trig` passes through a two-flop synchroniser, so a change sampled at edge e is accepted as a trigger at edge e+2.
- R10: `count` changes only on edges where `cnt_en` is high, except when it is cleared by a trigger or parked.
- R11: Once `enable` is sampled low, the next edge parks `count` at FFFFh and returns `pulse_out` to its idle level, and neither interrupt fires.
- R12: `pulse_out` equals `out_idle_lvl` when inactive and its inverse when active.
- R13: If delay is greater than end, no active level appears; `irq_end` still fires and `irq_delay` does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable, one tick per high cycle |
| enable | input | 1 | Timer enable; high arms the timer, low parks it |
| edge_sel | input | 2 | External trigger edge select (00 none, 01 rise, 10 fall, 11 both) |
| out_idle_lvl | input | 1 | Inactive level of `pulse_out` |
| end_val | input | 16 | Compare value for the last active count |
| delay_val | input | 16 | Compare value for the first active count |
| ext_trig | input | 1 | Asynchronous external trigger input |
| sw_trig | input | 1 | Software trigger strobe |
| pulse_out | output | 1 | Registered one-shot output |
| irq_end | output | 1 | Registered end-compare match pulse |
| irq_delay | output | 1 | Registered delay-compare match pulse |
| count | output | 16 | Current counter value |

## Verification
The hardest case to reach is a trigger that lands while a pulse is already running. The scoreboard has to show that the trigger leaves no trace, even when it arrives during the delay phase or during the active phase, and even when it is an external edge and not the strobe. The stimulus fires a long pulse, then injects software strobes and external edges at fixed offsets inside both phases without pushing any expected item. Any extra pulse or interrupt therefore shows up as a mismatch against an idle expectation. A gated count-enable pattern moves the tick edges away from the trigger edge, which separates the `irq_delay` cycle from the output's rising edge.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_ARMED = 2'b01,
    ST_RUN   = 2'b10
  } tmr_state_e;

endpackage

// File: rtl/os_trig_detect.sv
module os_trig_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_trig,
  input  logic [1:0] edge_sel,
  input  logic       sw_trig,
  output logic       trig
);
  import oneshot_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced;
  logic                   rise_det;
  logic                   fall_det;
  logic                   ext_hit;

  // synchroniser chain, one flop per stage
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= ext_trig;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b0;
        else     sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= synced;
  end

  assign rise_det = synced & ~prev_q;
  assign fall_det = ~synced & prev_q;

  always_comb begin
    unique case (edge_sel_e'(edge_sel))
      EDGE_RISE: ext_hit = rise_det;
      EDGE_FALL: ext_hit = fall_det;
      EDGE_BOTH: ext_hit = rise_det | fall_det;
      default:   ext_hit = 1'b0;
    endcase
  end

  assign trig = ext_hit | sw_trig;

endmodule

// File: rtl/os_counter_core.sv
module os_counter_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             cnt_en,
  input  logic             trig,
  input  logic [CNT_W-1:0] end_val,
  input  logic [CNT_W-1:0] delay_val,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             in_window,
  output logic             hit_end,
  output logic             hit_delay
);
  import oneshot_pkg::*;

  localparam logic [CNT_W-1:0] PARK = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  tmr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] buf_end_q;
  logic [CNT_W-1:0] buf_dly_q;
  logic             tick;
  logic             at_end;

  assign tick   = (state_q == ST_RUN) && cnt_en;
  assign at_end = (cnt_q == buf_end_q);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state_q <= ST_OFF;
      cnt_q   <= PARK;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_q <= ST_ARMED;
          cnt_q   <= PARK;
        end
        ST_ARMED: begin
          if (trig) begin
            state_q <= ST_RUN;
            cnt_q   <= ZERO;
          end
        end
        ST_RUN: begin
          if (tick) begin
            if (at_end) begin
              state_q <= ST_ARMED;
              cnt_q   <= PARK;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
        end
        default: begin
          state_q <= ST_OFF;
          cnt_q   <= PARK;
        end
      endcase
    end
  end

  // compare buffers: captured only when a trigger is accepted
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_end_q <= '0;
      buf_dly_q <= '0;
    end else if (enable && state_q == ST_ARMED && trig) begin
      buf_end_q <= end_val;
      buf_dly_q <= delay_val;
    end
  end

  assign count     = cnt_q;
  assign running   = (state_q == ST_RUN);
  assign in_window = running && (cnt_q >= buf_dly_q);
  assign hit_end   = tick && at_end;
  assign hit_delay = tick && (cnt_q == buf_dly_q);

endmodule

// File: rtl/os_out_stage.sv
module os_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic out_idle_lvl,
  input  logic in_window,
  input  logic hit_end,
  input  logic hit_delay,
  output logic pulse_out,
  output logic irq_end,
  output logic irq_delay
);

  logic pulse_q;
  logic irq_end_q;
  logic irq_dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q   <= out_idle_lvl;
      irq_end_q <= 1'b0;
      irq_dly_q <= 1'b0;
    end else begin
      pulse_q   <= out_idle_lvl ^ (enable && in_window);
      irq_end_q <= enable && hit_end;
      irq_dly_q <= enable && hit_delay;
    end
  end

  assign pulse_out = pulse_q;
  assign irq_end   = irq_end_q;
  assign irq_delay = irq_dly_q;

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             enable,
  input  logic [1:0]       edge_sel,
  input  logic             out_idle_lvl,
  input  logic [CNT_W-1:0] end_val,
  input  logic [CNT_W-1:0] delay_val,
  input  logic             ext_trig,
  input  logic             sw_trig,
  output logic             pulse_out,
  output logic             irq_end,
  output logic             irq_delay,
  output logic [CNT_W-1:0] count
);

  logic trig;
  logic running;
  logic in_window;
  logic hit_end;
  logic hit_delay;

  os_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk      (clk),
    .rst      (rst),
    .ext_trig (ext_trig),
    .edge_sel (edge_sel),
    .sw_trig  (sw_trig),
    .trig     (trig)
  );

  os_counter_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .cnt_en    (cnt_en),
    .trig      (trig),
    .end_val   (end_val),
    .delay_val (delay_val),
    .count     (count),
    .running   (running),
    .in_window (in_window),
    .hit_end   (hit_end),
    .hit_delay (hit_delay)
  );

  os_out_stage u_out (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .out_idle_lvl (out_idle_lvl),
    .in_window    (in_window),
    .hit_end      (hit_end),
    .hit_delay    (hit_delay),
    .pulse_out    (pulse_out),
    .irq_end      (irq_end),
    .irq_delay    (irq_delay)
  );

endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             cnt_en,
  input logic             out_idle_lvl,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic             pulse_out,
  input logic             irq_end,
  input logic             irq_delay
);

  localparam logic [CNT_W-1:0] PARK = {CNT_W{1'b1}};

  AST_OFF_PARKS: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (count == PARK && pulse_out == $past(out_idle_lvl) && !irq_end && !irq_delay)); // R11

  AST_IDLE_IS_PARKED: assert property (@(posedge clk) disable iff (rst)
    !running |-> count == PARK); // R5

  AST_LEAVE_PARK_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!running && count == PARK) |=> (count == PARK || count == '0)); // R2

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    (enable && running && !cnt_en) |=> $stable(count)); // R10

  AST_IRQ_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_end |=> !irq_end); // R7

  AST_IRQ_DELAY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_delay |=> !irq_delay); // R7

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !running |=> pulse_out == $past(out_idle_lvl)); // R12

  AST_END_REPARKS: assert property (@(posedge clk) disable iff (rst)
    irq_end |-> (count == PARK && !running)); // R5

endmodule

bind oneshot_timer oneshot_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .enable       (enable),
  .cnt_en       (cnt_en),
  .out_idle_lvl (out_idle_lvl),
  .running      (running),
  .count        (count),
  .pulse_out    (pulse_out),
  .irq_end      (irq_end),
  .irq_delay    (irq_delay)
);

// File: tb/oneshot_timer_tb.sv
module oneshot_timer_tb;

  localparam int W    = 16;
  localparam int SYNC = 2;
  localparam time TCK = 20ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cnt_en = 1'b1;
  logic          enable = 1'b0;
  logic [1:0]    edge_sel = 2'b00;
  logic          out_idle_lvl = 1'b0;
  logic [W-1:0]  end_val = '0;
  logic [W-1:0]  delay_val = '0;
  logic          ext_trig = 1'b0;
  logic          sw_trig = 1'b0;
  logic          pulse_out;
  logic          irq_end;
  logic          irq_delay;
  logic [W-1:0]  count;

  oneshot_timer #(.CNT_W(W), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .enable(enable), .edge_sel(edge_sel),
    .out_idle_lvl(out_idle_lvl), .end_val(end_val), .delay_val(delay_val),
    .ext_trig(ext_trig), .sw_trig(sw_trig), .pulse_out(pulse_out),
    .irq_end(irq_end), .irq_delay(irq_delay), .count(count)
  );

  always #(TCK/2) clk = ~clk;

  typedef struct {
    int rise;
    int last;
    int irq_dly;
    int irq_end;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   div = 1;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   mon_on = 1'b0;
  logic idle_s = 1'b0;

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    idle_s <= out_idle_lvl;
  end

  // count-clock enable pattern: high on edges that are multiples of div
  always @(negedge clk) cnt_en <= ((cyc + 1) % div == 0);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int tick_at(input int p, input int c);
    if (c == 0) return p;
    return ((p / div) + 1) * div + (c - 1) * div;
  endfunction

  function automatic exp_t make_exp(input int p, input int e, input int d);
    exp_t it;
    it.irq_end = tick_at(p, e + 1);
    if (d <= e) begin
      it.rise    = tick_at(p, d) + 1;
      it.last    = tick_at(p, e + 1);
      it.irq_dly = tick_at(p, d + 1);
    end else begin
      it.rise    = 1;
      it.last    = 0;
      it.irq_dly = -1;
    end
    return it;
  endfunction

  // monitor: compares outputs against the head of the scoreboard each cycle
  always @(negedge clk) begin
    bit act;
    bit ie;
    bit id;
    if (mon_on && !rst) begin
      while (exp_q.size() > 0 && cyc > exp_q[0].irq_end) void'(exp_q.pop_front());
      act = 1'b0; ie = 1'b0; id = 1'b0;
      if (exp_q.size() > 0) begin
        act = (cyc >= exp_q[0].rise) && (cyc <= exp_q[0].last);
        ie  = (cyc == exp_q[0].irq_end);
        id  = (cyc == exp_q[0].irq_dly);
      end
      chk(pulse_out === (idle_s ^ act), "R3 R4 R12 pulse level", pulse_out, idle_s ^ act);
      chk(irq_end === ie, "R7 irq_end", irq_end, ie);
      chk(irq_delay === id, "R7 R13 irq_delay", irq_delay, id);
    end
  end

  task automatic wait_until(input int c);
    while (cyc <= c) @(negedge clk);
  endtask

  task automatic fire_sw(input int e, input int d);
    exp_t it;
    int p;
    @(negedge clk);
    end_val = W'(e); delay_val = W'(d); sw_trig = 1'b1;
    p = cyc + 1;
    it = make_exp(p, e, d);
    exp_q.push_back(it);
    @(negedge clk);
    sw_trig = 1'b0;
    chk(count == 16'h0000, "R2 count cleared at trigger", count, 16'h0000);
    wait_until(it.irq_end + 1);
    chk(count == 16'hFFFF, "R5 parked after pulse", count, 16'hFFFF);
  endtask

  task automatic ext_edge(input bit v, input bit expect_trig, input int e, input int d, input string tag);
    exp_t it;
    int p;
    @(negedge clk);
    end_val = W'(e); delay_val = W'(d); ext_trig = v;
    if (expect_trig) begin
      p = cyc + 1 + SYNC;
      it = make_exp(p, e, d);
      exp_q.push_back(it);
      wait_until(it.irq_end + 1);
    end else begin
      repeat (8) @(negedge clk);
    end
    chk(count == 16'hFFFF, tag, count, 16'hFFFF);
  endtask

  initial begin : watchdog
    #(TCK * 200000);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    exp_t it;
    int p;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset / disabled state
    chk(count == 16'hFFFF, "R1 count after reset", count, 16'hFFFF);
    chk(pulse_out == 1'b0, "R1 pulse idle after reset", pulse_out, 1'b0);
    chk(!irq_end && !irq_delay, "R1 irqs low after reset", {irq_end, irq_delay}, 0);
    enable = 1'b1;
    mon_on = 1'b1;
    repeat (6) @(negedge clk);
    chk(count == 16'hFFFF, "R1 enable alone does not count", count, 16'hFFFF);

    // R3 R4: basic pulses and boundaries
    fire_sw(10, 3);
    fire_sw(0, 0);
    fire_sw(5, 5);
    fire_sw(7, 0);

    // R6: triggers during delay and active phases are ignored
    edge_sel = 2'b11;
    @(negedge clk);
    end_val = 16'd20; delay_val = 16'd6; sw_trig = 1'b1;
    p = cyc + 1;
    it = make_exp(p, 20, 6);
    exp_q.push_back(it);
    @(negedge clk) sw_trig = 1'b0;
    wait_until(p + 2);  sw_trig = 1'b1;
    @(negedge clk) sw_trig = 1'b0;
    ext_trig = 1'b1;
    wait_until(p + 12); sw_trig = 1'b1;
    @(negedge clk) sw_trig = 1'b0;
    ext_trig = 1'b0;
    wait_until(it.irq_end + 1);
    repeat (6) @(negedge clk);
    chk(count == 16'hFFFF, "R6 retrigger ignored", count, 16'hFFFF);
    edge_sel = 2'b00;

    // R8: compare changes mid-pulse do not affect it
    @(negedge clk);
    end_val = 16'd12; delay_val = 16'd6; sw_trig = 1'b1;
    p = cyc + 1;
    it = make_exp(p, 12, 6);
    exp_q.push_back(it);
    @(negedge clk) sw_trig = 1'b0;
    end_val = 16'd3; delay_val = 16'd1;
    wait_until(it.irq_end + 1);
    chk(count == 16'hFFFF, "R8 buffered compares", count, 16'hFFFF);

    // R9: external edge selection
    edge_sel = 2'b01;
    ext_edge(1'b1, 1'b1, 4, 1, "R9 rising edge triggers");
    ext_edge(1'b0, 1'b0, 4, 1, "R9 falling edge ignored in rise mode");
    edge_sel = 2'b10;
    ext_edge(1'b1, 1'b0, 4, 1, "R9 rising edge ignored in fall mode");
    ext_edge(1'b0, 1'b1, 3, 2, "R9 falling edge triggers");
    edge_sel = 2'b11;
    ext_edge(1'b1, 1'b1, 2, 0, "R9 both mode rise");
    ext_edge(1'b0, 1'b1, 6, 3, "R9 both mode fall");
    edge_sel = 2'b00;
    ext_edge(1'b1, 1'b0, 4, 1, "R9 none mode rise");
    ext_edge(1'b0, 1'b0, 4, 1, "R9 none mode fall");

    // R10: gated count-clock enable
    div = 3;
    repeat (3) @(negedge clk);
    fire_sw(4, 2);
    fire_sw(5, 0);
    div = 1;
    repeat (3) @(negedge clk);

    // R12: inverted idle level
    out_idle_lvl = 1'b1;
    repeat (3) @(negedge clk);
    chk(pulse_out == 1'b1, "R12 idle high", pulse_out, 1'b1);
    fire_sw(6, 2);
    out_idle_lvl = 1'b0;
    repeat (3) @(negedge clk);

    // R13: delay beyond end gives no active level
    fire_sw(3, 7);

    // R11: disabling mid-pulse
    mon_on = 1'b0;
    @(negedge clk);
    end_val = 16'd10; delay_val = 16'd2; sw_trig = 1'b1;
    p = cyc + 1;
    @(negedge clk) sw_trig = 1'b0;
    wait_until(p + 5);
    chk(pulse_out == 1'b1, "R4 active before disable", pulse_out, 1'b1);
    enable = 1'b0;
    @(negedge clk);
    chk(count == 16'hFFFF, "R11 count parked on disable", count, 16'hFFFF);
    chk(pulse_out == 1'b0, "R11 output idle on disable", pulse_out, 1'b0);
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      chk(!irq_end && !irq_delay, "R11 no interrupt while disabled", {irq_end, irq_delay}, 0);
    end
    enable = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;
    fire_sw(8, 4);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule